// File: doc/BRIEF.md
# Programmable Countdown Interval Timer

This block is a down-counting timer that software controls through four word registers on a simple register bus with separate read and write strobes. Software first programs a period, which is loaded into the live counter at once, then writes a control word whose command bits start or halt counting and pick between one-shot and auto-reload behaviour. While running, the counter decrements by one on every clock edge. When it expires, a sticky timeout flag is set. The interrupt output is a level: it is high while that flag is set and the interrupt enable in the stored control word is set.

The sequencing core has two named states. `ST_IDLE` holds the count. `ST_RUN` decrements it. The transitions are:
- **start**: `ST_IDLE` to `ST_RUN`, on a control write with the start bit set and the stop bit clear.
- **halt**: `ST_RUN` to `ST_IDLE`, on a control write with the stop bit set.
- **expire-stop**: `ST_RUN` to `ST_IDLE`, on expiry in one-shot mode.
- **expire-reload**: `ST_RUN` to `ST_RUN`, on expiry in continuous mode.
- **count**: `ST_RUN` to `ST_RUN`, on every other cycle.

A command write takes effect on the edge where it is written. In that same edge, the count still moves according to the state that held before the edge.

Top module: `tmr_interval`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped and `irq` is low.
- R2: Word index = `bus_addr[4:2]`. Indices 0 to 3 are status, control, period and snapshot. An access whose index is 4 or more, or whose two low address bits are nonzero, is unmapped: it reads as zero and a write to it changes nothing.
- R3: A write to control (index 1) stores the whole 32-bit word, and the word reads back unchanged. Control bit 0 is the interrupt enable, bit 1 selects continuous mode, bit 2 is start and bit 3 is stop.
- R4: A control write with bit 2 set and bit 3 clear makes the counter run. A control write with bit 3 set halts it, even when bit 2 is also set. While halted, the count holds its value.
- R5: A write to period (index 2) stores the value and loads the counter with it on the same edge.
- R6: While running, the counter decreases by exactly one per clock. Reading snapshot (index 3) returns the live count.
- R7: A running counter at 1 or at 0 expires on the next edge, and that expiry sets the timeout flag (status bit 0). In one-shot mode (control bit 1 clear), the counter is then 0 and stopped.
- R8: In continuous mode (control bit 1 set), expiry reloads the counter from period and counting continues. Expiries are therefore spaced period cycles apart.
- R9: Any write to status (index 0) clears the timeout flag, whatever the data. The running flag (status bit 1) is not affected. If an expiry falls on the same edge as the write, the flag ends up set.
- R10: `irq` equals the timeout flag ANDed with control bit 0.
- R11: A write to snapshot changes no register and does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe; the write takes effect on the rising edge |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when there is no read or the access is unmapped |
| irq | output | 1 | Level interrupt |

## Verification
A wrong state in the sequencer shows up within one clock: the running bit in status disagrees with the last command, or the snapshot either stops moving or moves while the counter should be halted. A wrong count or reload value becomes visible at the next snapshot read. It also shows in when the timeout flag and `irq` rise: a sweep over short periods checks that the flag rises on exactly the edge the period predicts, and an off-by-one delay in expiry moves that edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;

    localparam int NUM_REGS   = 4;
    localparam int IDX_STATUS = 0;
    localparam int IDX_CTRL   = 1;
    localparam int IDX_PERIOD = 2;
    localparam int IDX_SNAP   = 3;

    localparam int CB_IE    = 0;
    localparam int CB_CONT  = 1;
    localparam int CB_START = 2;
    localparam int CB_STOP  = 3;

    localparam int SB_TO  = 0;
    localparam int SB_RUN = 1;
endpackage

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cont,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             expire
);
    run_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign expire  = (state_q == ST_RUN) && ((cnt_q == '0) || (cnt_q == CNT_W'(1)));
    assign running = (state_q == ST_RUN);
    assign cnt     = cnt_q;

    // next-state selection: the expiry outcome first, then command override (stop wins)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_RUN:  state_d = (expire && !cont) ? ST_IDLE : ST_RUN;
        endcase
        if (cmd_stop)
            state_d = ST_IDLE;
        else if (cmd_start)
            state_d = ST_RUN;
    end

    // counter datapath; a period load overrides the count step
    always_comb begin
        cnt_d = cnt_q;
        unique case (state_q)
            ST_IDLE: cnt_d = cnt_q;
            ST_RUN: begin
                if (expire)
                    cnt_d = cont ? reload_val : '0;
                else
                    cnt_d = cnt_q - CNT_W'(1);
            end
        endcase
        if (load)
            cnt_d = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (state_q == ST_IDLE)); // R4
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_stop) |=> (state_q == ST_RUN)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load) |=> (cnt_q == $past(cnt_q))); // R4
    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val))); // R5
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !expire && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R6
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cont && !cmd_start && !load) |=> (state_q == ST_IDLE && cnt_q == '0)); // R7
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cont && !load && !cmd_stop) |=> (state_q == ST_RUN && cnt_q == $past(reload_val))); // R8
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire,
    input  logic              running,
    input  logic [DATA_W-1:0] cnt,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              load,
    output logic              cont,
    output logic [DATA_W-1:0] period,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              mapped;
    logic              wr_status, wr_ctrl, wr_period, wr_snap;
    logic [DATA_W-1:0] ctrl_q, period_q;
    logic              flag_q;

    assign idx    = bus_addr[ADDR_W-1:2];
    assign mapped = (bus_addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));

    assign wr_status = bus_wr && mapped && (idx == IDX_W'(IDX_STATUS));
    assign wr_ctrl   = bus_wr && mapped && (idx == IDX_W'(IDX_CTRL));
    assign wr_period = bus_wr && mapped && (idx == IDX_W'(IDX_PERIOD));
    assign wr_snap   = bus_wr && mapped && (idx == IDX_W'(IDX_SNAP));

    assign cmd_start = wr_ctrl && bus_wdata[CB_START];
    assign cmd_stop  = wr_ctrl && bus_wdata[CB_STOP];
    assign load      = wr_period;
    assign cont      = ctrl_q[CB_CONT];
    assign period    = period_q;
    assign irq       = flag_q && ctrl_q[CB_IE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= bus_wdata;
            if (wr_period)
                period_q <= bus_wdata;
            if (expire)
                flag_q <= 1'b1;
            else if (wr_status)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && mapped) begin
            case (idx)
                IDX_W'(IDX_STATUS): begin
                    bus_rdata[SB_TO]  = flag_q;
                    bus_rdata[SB_RUN] = running;
                end
                IDX_W'(IDX_CTRL):   bus_rdata = ctrl_q;
                IDX_W'(IDX_PERIOD): bus_rdata = period_q;
                IDX_W'(IDX_SNAP):   bus_rdata = cnt;
                default:            bus_rdata = '0;
            endcase
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !expire) |=> !flag_q); // R9
    AST_SNAP_RO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_snap |=> ($stable(ctrl_q) && $stable(period_q))); // R11
    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> ($stable(ctrl_q) && $stable(period_q))); // R2
endmodule

// File: rtl/tmr_interval.sv
`timescale 1ns/1ps
module tmr_interval #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              cmd_start, cmd_stop, load, cont, running, expire;
    logic [DATA_W-1:0] period, cnt;

    tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .expire    (expire),
        .running   (running),
        .cnt       (cnt),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .load      (load),
        .cont      (cont),
        .period    (period),
        .irq       (irq)
    );

    tmr_core #(.CNT_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .load       (load),
        .load_val   (bus_wdata),
        .cont       (cont),
        .reload_val (period),
        .cnt        (cnt),
        .running    (running),
        .expire     (expire)
    );
endmodule

// File: tb/tmr_interval_test.sv
`timescale 1ns/1ps
module tmr_interval_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [4:0] A_ST = 5'h00, A_CT = 5'h04, A_PR = 5'h08, A_SN = 5'h0C;

    always #4 clk = ~clk;

    tmr_interval uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req, input string what);
        bus_addr = a; bus_rd = 1'b1;
        #0.1;
        check(req, what, bus_rdata, exp);
        bus_rd = 1'b0;
        #0.1;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(A_ST, 0, "R1", "status");
        rd_chk(A_CT, 0, "R1", "control");
        rd_chk(A_PR, 0, "R1", "period");
        rd_chk(A_SN, 0, "R1", "snapshot");
        check("R1", "irq", {31'd0, irq}, 0);

        // R2 unmapped and misaligned accesses
        wr_reg(5'h10, 32'hFFFF_FFFF);
        wr_reg(5'h1C, 32'h7);
        wr_reg(5'h09, 32'h1234);
        wr_reg(5'h05, 32'h4);
        rd_chk(5'h10, 0, "R2", "unmapped 0x10");
        rd_chk(5'h1C, 0, "R2", "unmapped 0x1C");
        rd_chk(A_PR, 0, "R2", "period after misaligned write");
        rd_chk(A_CT, 0, "R2", "control after misaligned write");
        rd_chk(A_ST, 0, "R2", "no run after misaligned start");

        // R5 period load
        wr_reg(A_PR, 10);
        rd_chk(A_SN, 10, "R5", "snapshot after period write");
        rd_chk(A_PR, 10, "R5", "period readback");

        // R3 R4 start, R6 decrement sweep
        wr_reg(A_CT, 32'h4);
        rd_chk(A_CT, 32'h4, "R3", "control readback");
        rd_chk(A_ST, 2, "R4", "running after start");
        for (int j = 1; j <= 9; j++) begin
            @(negedge clk);
            rd_chk(A_SN, 32'(10 - j), "R6", "count step");
        end
        @(negedge clk);
        rd_chk(A_SN, 0, "R7", "one-shot end count");
        rd_chk(A_ST, 1, "R7", "timeout set, stopped");
        check("R10", "irq with enable clear", {31'd0, irq}, 0);
        repeat (3) @(negedge clk);
        rd_chk(A_SN, 0, "R7", "stays at zero");
        rd_chk(A_ST, 1, "R7", "stays stopped");

        // R10 enable, R9 clear
        wr_reg(A_CT, 32'h1);
        check("R10", "irq with enable set", {31'd0, irq}, 1);
        wr_reg(A_ST, 32'h0);
        rd_chk(A_ST, 0, "R9", "flag cleared by zero data");
        check("R10", "irq after clear", {31'd0, irq}, 0);

        // R3 full word stored
        wr_reg(A_CT, 32'hA5A5_0001);
        rd_chk(A_CT, 32'hA5A5_0001, "R3", "full word");

        // R8 continuous
        wr_reg(A_PR, 5);
        wr_reg(A_CT, 32'h7);
        for (int j = 1; j <= 16; j++) begin
            @(negedge clk);
            rd_chk(A_SN, 32'(5 - (j % 5)), "R8", "reload count");
            rd_chk(A_ST, (j >= 5) ? 32'd3 : 32'd2, "R8", "status in continuous");
            check("R10", "irq in continuous", {31'd0, irq}, (j >= 5) ? 32'd1 : 32'd0);
        end

        // R4 stop (count steps once more on the stop edge)
        wr_reg(A_CT, 32'h8);
        rd_chk(A_SN, 3, "R4", "count at stop");
        repeat (4) @(negedge clk);
        rd_chk(A_SN, 3, "R4", "count held");
        rd_chk(A_ST, 1, "R4", "stopped, flag kept");
        wr_reg(A_CT, 32'h4);
        wr_reg(A_CT, 32'hC);
        rd_chk(A_ST, 1, "R4", "stop wins over start");
        repeat (3) @(negedge clk);
        rd_chk(A_SN, 2, "R4", "held after both bits");

        // R7 start at zero
        wr_reg(A_ST, 0);
        wr_reg(A_PR, 0);
        wr_reg(A_CT, 32'h4);
        rd_chk(A_ST, 2, "R7", "running from zero");
        @(negedge clk);
        rd_chk(A_ST, 1, "R7", "zero start expires next edge");
        rd_chk(A_SN, 0, "R7", "zero count");

        // R11 snapshot read-only
        wr_reg(A_PR, 32'h40);
        wr_reg(A_SN, 32'h55);
        rd_chk(A_SN, 32'h40, "R11", "snapshot unchanged");
        rd_chk(A_PR, 32'h40, "R11", "period unchanged");
        rd_chk(A_CT, 32'h4, "R11", "control unchanged");

        // R9 running bit unaffected
        wr_reg(A_ST, 0);
        wr_reg(A_CT, 32'h4);
        wr_reg(A_ST, 32'hFFFF_FFFF);
        rd_chk(A_ST, 2, "R9", "running kept");
        rd_chk(A_SN, 32'h3F, "R9", "count kept moving");
        wr_reg(A_CT, 32'h8);

        // R9 expiry on the same edge as a status write
        wr_reg(A_PR, 2);
        wr_reg(A_CT, 32'h4);
        @(negedge clk);
        wr_reg(A_ST, 0);
        rd_chk(A_ST, 1, "R9", "expiry wins over clear");

        // R7 one-shot sweep over short periods
        for (int p = 1; p <= 8; p++) begin
            wr_reg(A_ST, 0);
            wr_reg(A_PR, 32'(p));
            wr_reg(A_CT, 32'h4);
            repeat (p - 1) @(negedge clk);
            rd_chk(A_ST, 2, "R7", "before expiry");
            @(negedge clk);
            rd_chk(A_ST, 1, "R7", "at expiry");
            rd_chk(A_SN, 0, "R7", "count at expiry");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule